// File: doc/BRIEF.md
# FIFO Error Status and Interrupt Unit

This block sits beside a processing engine and guards its two byte FIFOs: an input FIFO of 256 entries that the host fills and the engine drains, and a smaller output FIFO that the engine fills and the host drains. It watches the FIFO strobes, the data-size write strobe, the engine's done event and every access on its small register bus. It turns FIFO protocol violations and bad register addresses into sticky error bits. Each error bit can be suppressed by a mask register with the same field layout.

Any recorded error that is not masked raises the error interrupt and the halt request to the engine. Both stay high until software clears the recorded bits by writing ones to them. The FIFOs are first-word-fall-through: the head byte is always visible on the pop-side data port, and reads zero while the FIFO is empty.

Top module: `fifo_err_unit`

## Requirements
- R1: Register word index 0 is the error status and index 1 is the error mask; reads are combinational from `regAddr`. Both use one layout: bit 0 bad address, bit 1 output FIFO not empty at size write, bit 2 input FIFO not empty at done, bit 4 input overflow, bit 5 output underflow. Every other bit reads 0 and ignores writes. Both registers are 0 after reset.
- R2: While a mask bit is 1, its error condition neither sets the status bit nor raises `errIrq` or `haltReq`.
- R3: An unmasked error seen at a clock edge sets its status bit at that edge, and `errIrq` and `haltReq` are high from then on. Several errors in one cycle set all their bits.
- R4: A push while the input FIFO holds 256 bytes (`inFull`) flags input overflow, and the byte is not stored.
- R5: A host read while the output FIFO is empty flags output underflow. `outReadData` is 0 and the FIFO state does not change.
- R6: A size write while the output FIFO holds data flags the output-not-empty error. A size write with the output FIFO empty flags nothing.
- R7: A done event while the input FIFO holds data flags the input-not-empty error.
- R8: A read or write strobe with `regAddr` other than 0 or 1 flags the bad-address error. Such a write changes no register, and a read of such an address returns 0.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. A new error on the same bit in the same cycle wins over the clear.
- R10: `errIrq` and `haltReq` are high exactly while some status bit is 1 with its mask bit 0. They fall once all such bits are cleared or masked.
- R11: Both FIFOs deliver bytes in push order on their pop-side data ports, with `inFull`, `inEmpty`, `outFull` and `outEmpty` tracking their fill level. A pop of an empty FIFO or a push to a full one does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word index |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data (combinational) |
| inPush | input | 1 | Host push into input FIFO |
| inPushData | input | DATA_W | Byte pushed into input FIFO |
| inPop | input | 1 | Engine pop from input FIFO |
| inPopData | output | DATA_W | Input FIFO head byte, 0 when empty |
| inFull | output | 1 | Input FIFO full |
| inEmpty | output | 1 | Input FIFO empty |
| outPush | input | 1 | Engine push into output FIFO |
| outPushData | input | DATA_W | Byte pushed into output FIFO |
| outRead | input | 1 | Host read from output FIFO |
| outReadData | output | DATA_W | Output FIFO head byte, 0 when empty |
| outFull | output | 1 | Output FIFO full |
| outEmpty | output | 1 | Output FIFO empty |
| sizeWrite | input | 1 | Data-size register write strobe |
| doneEvent | input | 1 | Engine done event |
| errIrq | output | 1 | Error interrupt |
| haltReq | output | 1 | Halt request to the engine |

## Verification
Status bits, FIFO flags and the queued bytes change at the clock edge that samples the stimulus. The bench therefore expects them at the falling edge that follows that stimulus cycle. `errIrq`, `haltReq`, `regRdData` and the head-byte ports are combinational from that registered state and the current address, so they are due in the same half-cycle as the status they reflect. A behavioural reference model with queues updates on each rising edge and is compared with every output one time step after each falling edge. Directed checks read the status back at the falling edge that ends each stimulus.

// File: rtl/feu_pkg.sv
package feu_pkg;
  localparam int REG_W = 64;

  localparam int BIT_ADDR    = 0;
  localparam int BIT_OUT_NE  = 1;
  localparam int BIT_IN_NE   = 2;
  localparam int BIT_IN_OVF  = 4;
  localparam int BIT_OUT_UNF = 5;
  localparam int CHK_BITS    = 6;

  localparam logic [REG_W-1:0] IMPL_MASK = 64'h37;

  localparam int STATUS_IDX = 0;
  localparam int MASK_IDX   = 1;

  typedef struct packed {
    logic inWrite;
    logic inRead;
    logic outWrite;
    logic outRead;
  } fifoStrobes_t;
endpackage

// File: rtl/feu_fifo.sv
module feu_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rd,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wr) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (rd) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({wr, rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= wrData;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) full |-> !wr); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) empty |-> !rd); // R5
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (wr && !rd) |=> (count == $past(count) + CNT_W'(1))); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wr && !rd) |=> $stable(count) && $stable(rdPtr)); // R11
endmodule

// File: rtl/feu_datapath.sv
module feu_datapath
  import feu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IN_DEPTH  = 256,
  parameter int OUT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] inPushData,
  input  logic [DATA_W-1:0] outPushData,
  output logic [DATA_W-1:0] inPopData,
  output logic [DATA_W-1:0] outReadData,
  output logic              inFull,
  output logic              inEmpty,
  output logic              outFull,
  output logic              outEmpty
);
  feu_fifo #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) inFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .wr       (strobes.inWrite),
    .wrData   (inPushData),
    .rd       (strobes.inRead),
    .headData (inPopData),
    .full     (inFull),
    .empty    (inEmpty)
  );

  feu_fifo #(.DATA_W(DATA_W), .DEPTH(OUT_DEPTH)) outFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .wr       (strobes.outWrite),
    .wrData   (outPushData),
    .rd       (strobes.outRead),
    .headData (outReadData),
    .full     (outFull),
    .empty    (outEmpty)
  );

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> (outReadData == '0)); // R5
endmodule

// File: rtl/feu_control.sv
module feu_control
  import feu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              inPush,
  input  logic              inPop,
  input  logic              outPush,
  input  logic              outRead,
  input  logic              sizeWrite,
  input  logic              doneEvent,
  input  logic              inFull,
  input  logic              inEmpty,
  input  logic              outFull,
  input  logic              outEmpty,
  output fifoStrobes_t      strobes,
  output logic              errIrq,
  output logic              haltReq
);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(STATUS_IDX);
  localparam logic [ADDR_W-1:0] ADDR_MASK   = ADDR_W'(MASK_IDX);

  logic             addrLegal, statusWr, maskWr;
  logic [REG_W-1:0] errNow, statusReg, maskReg, clrBits, statusNext, pending;

  assign addrLegal = (regAddr == ADDR_STATUS) || (regAddr == ADDR_MASK);
  assign statusWr  = regWrEn && (regAddr == ADDR_STATUS);
  assign maskWr    = regWrEn && (regAddr == ADDR_MASK);

  always_comb begin
    errNow              = '0;
    errNow[BIT_ADDR]    = (regWrEn || regRdEn) && !addrLegal;
    errNow[BIT_OUT_NE]  = sizeWrite && !outEmpty;
    errNow[BIT_IN_NE]   = doneEvent && !inEmpty;
    errNow[BIT_IN_OVF]  = inPush && inFull;
    errNow[BIT_OUT_UNF] = outRead && outEmpty;
  end

  assign clrBits    = statusWr ? (regWrData & IMPL_MASK) : '0;
  assign statusNext = (statusReg & ~clrBits) | (errNow & ~maskReg & IMPL_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      maskReg   <= '0;
    end else begin
      statusReg <= statusNext;
      if (maskWr) maskReg <= regWrData & IMPL_MASK;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdData = statusReg;
      ADDR_MASK:   regRdData = maskReg;
      default:     regRdData = '0;
    endcase
  end

  assign pending = statusReg & ~maskReg;
  assign errIrq  = |pending;
  assign haltReq = |pending;

  assign strobes.inWrite  = inPush && !inFull;
  assign strobes.inRead   = inPop && !inEmpty;
  assign strobes.outWrite = outPush && !outFull;
  assign strobes.outRead  = outRead && !outEmpty;

  for (genvar k = 0; k < CHK_BITS; k++) begin : g_bitChk
    if (IMPL_MASK[k]) begin : g_impl
      AST_MASKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        (maskReg[k] && !statusReg[k]) |=> !statusReg[k]); // R2
      AST_ERROR_RAISES: assert property (@(posedge clk) disable iff (!rstN)
        (errNow[k] && !maskReg[k] && !maskWr) |=> (statusReg[k] && errIrq && haltReq)); // R3
    end
  end

  AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !statusWr && !maskWr) |=> haltReq); // R10
  AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !addrLegal) |=> $stable(maskReg)); // R8
endmodule

// File: rtl/fifo_err_unit.sv
module fifo_err_unit
  import feu_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int IN_DEPTH  = 256,
  parameter int OUT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              inPush,
  input  logic [DATA_W-1:0] inPushData,
  input  logic              inPop,
  output logic [DATA_W-1:0] inPopData,
  output logic              inFull,
  output logic              inEmpty,
  input  logic              outPush,
  input  logic [DATA_W-1:0] outPushData,
  input  logic              outRead,
  output logic [DATA_W-1:0] outReadData,
  output logic              outFull,
  output logic              outEmpty,
  input  logic              sizeWrite,
  input  logic              doneEvent,
  output logic              errIrq,
  output logic              haltReq
);
  fifoStrobes_t strobes;

  feu_control #(.ADDR_W(ADDR_W)) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .inPush    (inPush),
    .inPop     (inPop),
    .outPush   (outPush),
    .outRead   (outRead),
    .sizeWrite (sizeWrite),
    .doneEvent (doneEvent),
    .inFull    (inFull),
    .inEmpty   (inEmpty),
    .outFull   (outFull),
    .outEmpty  (outEmpty),
    .strobes   (strobes),
    .errIrq    (errIrq),
    .haltReq   (haltReq)
  );

  feu_datapath #(
    .DATA_W    (DATA_W),
    .IN_DEPTH  (IN_DEPTH),
    .OUT_DEPTH (OUT_DEPTH)
  ) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .inPushData  (inPushData),
    .outPushData (outPushData),
    .inPopData   (inPopData),
    .outReadData (outReadData),
    .inFull      (inFull),
    .inEmpty     (inEmpty),
    .outFull     (outFull),
    .outEmpty    (outEmpty)
  );
endmodule

// File: tb/fifo_err_unit_tb_top.sv
`timescale 1ns/1ps
module fifo_err_unit_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int IN_D   = 256;
  localparam int OUT_D  = 16;
  localparam logic [63:0] IMPL = 64'h37;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0, regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [63:0]       regWrData = '0;
  logic [63:0]       regRdData;
  logic              inPush = 1'b0, inPop = 1'b0, outPush = 1'b0, outRead = 1'b0;
  logic [DATA_W-1:0] inPushData = '0, outPushData = '0;
  logic [DATA_W-1:0] inPopData, outReadData;
  logic              inFull, inEmpty, outFull, outEmpty;
  logic              sizeWrite = 1'b0, doneEvent = 1'b0;
  logic              errIrq, haltReq;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;

  always #2 clk = ~clk;

  fifo_err_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_DEPTH(IN_D), .OUT_DEPTH(OUT_D)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inPush(inPush), .inPushData(inPushData),
    .inPop(inPop), .inPopData(inPopData), .inFull(inFull), .inEmpty(inEmpty),
    .outPush(outPush), .outPushData(outPushData), .outRead(outRead), .outReadData(outReadData),
    .outFull(outFull), .outEmpty(outEmpty), .sizeWrite(sizeWrite), .doneEvent(doneEvent),
    .errIrq(errIrq), .haltReq(haltReq)
  );

  // Behavioural reference model
  logic [63:0] mStatus = '0, mMask = '0;
  logic [DATA_W-1:0] inQ[$];
  logic [DATA_W-1:0] outQ[$];

  always @(posedge clk) begin : model_upd
    logic [63:0] err;
    logic [63:0] newMask;
    int inSz, outSz;
    if (!rstN) begin
      mStatus = '0;
      mMask = '0;
      inQ.delete();
      outQ.delete();
    end else begin
      inSz = inQ.size();
      outSz = outQ.size();
      err = '0;
      err[0] = (regWrEn || regRdEn) && (regAddr > 1);
      err[1] = sizeWrite && (outSz != 0);
      err[2] = doneEvent && (inSz != 0);
      err[4] = inPush && (inSz == IN_D);
      err[5] = outRead && (outSz == 0);
      newMask = mMask;
      if (regWrEn && regAddr == 1) newMask = regWrData & IMPL;
      if (regWrEn && regAddr == 0) mStatus = mStatus & ~(regWrData & IMPL);
      mStatus = mStatus | (err & ~mMask);
      mMask = newMask;
      if (inPop && inSz > 0) void'(inQ.pop_front());
      if (inPush && inSz < IN_D) inQ.push_back(inPushData);
      if (outRead && outSz > 0) void'(outQ.pop_front());
      if (outPush && outSz < OUT_D) outQ.push_back(outPushData);
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, one step after the falling edge
  always begin : per_cycle
    logic [63:0] expRd;
    logic pend;
    @(negedge clk);
    #1;
    if (checking) begin
      expRd = (regAddr == 0) ? mStatus : (regAddr == 1) ? mMask : 64'h0;
      pend = |(mStatus & ~mMask);
      cmp("R1 regRdData vs model", regRdData, expRd);
      cmp("R3 errIrq vs model", {63'h0, errIrq}, {63'h0, pend});
      cmp("R10 haltReq vs model", {63'h0, haltReq}, {63'h0, pend});
      cmp("R11 inFull", {63'h0, inFull}, {63'h0, inQ.size() == IN_D});
      cmp("R11 inEmpty", {63'h0, inEmpty}, {63'h0, inQ.size() == 0});
      cmp("R11 outFull", {63'h0, outFull}, {63'h0, outQ.size() == OUT_D});
      cmp("R11 outEmpty", {63'h0, outEmpty}, {63'h0, outQ.size() == 0});
      cmp("R11 inPopData", {56'h0, inPopData}, {56'h0, (inQ.size() > 0) ? inQ[0] : 8'h0});
      cmp("R5 outReadData", {56'h0, outReadData}, {56'h0, (outQ.size() > 0) ? outQ[0] : 8'h0});
    end
  end

  task automatic idleAll();
    regWrEn = 0; regRdEn = 0; inPush = 0; inPop = 0;
    outPush = 0; outRead = 0; sizeWrite = 0; doneEvent = 0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    idleAll();
  endtask

  task automatic pushIn(input logic [7:0] d);
    inPush = 1; inPushData = d; endCycle();
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; endCycle();
    regAddr = '0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [63:0] v);
    regAddr = a;
    #1;
    v = regRdData;
    @(negedge clk);
    regAddr = '0;
  endtask

  task automatic portCheck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    cmp(tag, act, exp);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checking = 1;

    // R1 reset state
    readReg(0, v); cmp("R1 status after reset", v, 64'h0);
    readReg(1, v); cmp("R1 mask after reset", v, 64'h0);
    #1; cmp("R10 halt idle after reset", {63'h0, haltReq}, 64'h0);
    @(negedge clk);

    // Fill input FIFO, then overflow (R4, R11)
    for (int i = 0; i < IN_D; i++) pushIn(8'(i));
    #1;
    cmp("R11 inFull after 256 pushes", {63'h0, inFull}, 64'h1);
    cmp("R11 head is first byte", {56'h0, inPopData}, 64'h0);
    @(negedge clk);
    pushIn(8'hAA);
    readReg(0, v); cmp("R4 overflow flagged", v, 64'h10);
    #1;
    cmp("R3 errIrq after overflow", {63'h0, errIrq}, 64'h1);
    cmp("R3 haltReq after overflow", {63'h0, haltReq}, 64'h1);
    @(negedge clk);

    // R9 write zero keeps, write one clears; R10 release
    regWrite(0, 64'h0);
    readReg(0, v); cmp("R9 writing zero keeps bit", v, 64'h10);
    #1; cmp("R10 halt held", {63'h0, haltReq}, 64'h1);
    @(negedge clk);
    regWrite(0, 64'h10);
    readReg(0, v); cmp("R9 writing one clears bit", v, 64'h0);
    #1; cmp("R10 halt released", {63'h0, haltReq}, 64'h0);
    @(negedge clk);

    // R2 masked overflow
    regWrite(1, 64'h10);
    pushIn(8'hBB);
    readReg(0, v); cmp("R2 masked error not recorded", v, 64'h0);
    #1; cmp("R2 no irq when masked", {63'h0, errIrq}, 64'h0);
    @(negedge clk);
    readReg(1, v); cmp("R1 mask readback", v, 64'h10);
    inPop = 1; endCycle();
    #1; cmp("R11 second byte at head", {56'h0, inPopData}, 64'h1);
    @(negedge clk);
    regWrite(1, 64'h0);

    // R5 underflow
    outRead = 1;
    #1; cmp("R5 empty read returns zero", {56'h0, outReadData}, 64'h0);
    endCycle();
    readReg(0, v); cmp("R5 underflow flagged", v, 64'h20);
    #1; cmp("R5 output still empty", {63'h0, outEmpty}, 64'h1);
    @(negedge clk);
    regWrite(0, 64'h20);

    // R6 size write with output data, then with empty output
    outPush = 1; outPushData = 8'h5A; endCycle();
    sizeWrite = 1; endCycle();
    readReg(0, v); cmp("R6 output non-empty flagged", v, 64'h02);
    #1; cmp("R11 output head byte", {56'h0, outReadData}, 64'h5A);
    @(negedge clk);
    outRead = 1; endCycle();
    regWrite(0, 64'h02);
    sizeWrite = 1; endCycle();
    readReg(0, v); cmp("R6 no flag when output empty", v, 64'h0);

    // R7 done with input non-empty
    doneEvent = 1; endCycle();
    readReg(0, v); cmp("R7 input non-empty at done", v, 64'h04);
    regWrite(0, 64'h04);

    // R8 illegal address write and read
    regWrite(5, 64'h37);
    readReg(0, v); cmp("R8 bad write flagged", v, 64'h01);
    readReg(1, v); cmp("R8 bad write changed nothing", v, 64'h0);
    readReg(5, v); cmp("R8 illegal address reads zero", v, 64'h0);
    regWrite(0, 64'h01);
    regRdEn = 1; regAddr = 4'd9; endCycle(); regAddr = '0;
    readReg(0, v); cmp("R8 bad read flagged", v, 64'h01);
    regWrite(0, 64'h01);

    // R1 reserved bits ignore writes
    regWrite(1, 64'hFFFF_FFFF_FFFF_FFFF);
    readReg(1, v); cmp("R1 reserved mask bits read zero", v, 64'h37);
    regWrite(1, 64'h0);
    regWrite(0, 64'hFFFF_FFFF_FFFF_FFFF);
    readReg(0, v); cmp("R1 reserved status bits read zero", v, 64'h0);

    // R9 set wins over clear (refill to full first)
    pushIn(8'hC0);
    #1; cmp("R11 input full again", {63'h0, inFull}, 64'h1);
    @(negedge clk);
    inPush = 1; inPushData = 8'hC1;
    regWrEn = 1; regAddr = 0; regWrData = 64'h10;
    endCycle();
    readReg(0, v); cmp("R9 new error beats clear", v, 64'h10);

    // R10 masking releases halt while bit stays recorded
    regWrite(1, 64'h10);
    #1; cmp("R10 halt low when masked", {63'h0, haltReq}, 64'h0);
    @(negedge clk);
    readReg(0, v); cmp("R10 bit still recorded", v, 64'h10);
    regWrite(1, 64'h0);
    #1; cmp("R10 halt back when unmasked", {63'h0, haltReq}, 64'h1);
    @(negedge clk);
    regWrite(0, 64'h37);

    // R3 two errors in one cycle
    doneEvent = 1; outRead = 1; endCycle();
    readReg(0, v); cmp("R3 simultaneous errors", v, 64'h24);
    regWrite(0, 64'h24);
    #1; cmp("R10 cleared all", {63'h0, errIrq}, 64'h0);
    @(negedge clk);

    checking = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule